// File: doc/BRIEF.md
# Windowed Rail Supervisor Debounce

This block is the digital timing core of a window-type supply supervisor for one rail. It receives two already-synchronized comparator flags, one for undervoltage and one for overvoltage, and turns them into a power-good output. Each fault direction has its own qualifier with an assert time and a separate, longer release time. A fault must persist before power-good drops, and recovery must persist before it returns. All times are counted in ticks of a slow single-cycle enable pulse and come from static configuration ports.

When the supervisor is enabled, a startup grace interval hides both flags completely. This lets pre-bias ringing and soft-start overshoot settle without tripping anything, and it also blocks any overvoltage trip during startup. Once grace ends, both qualifiers start in the fault state. Power-good therefore first appears only after a full release interval of clean rail. Excursions that clear before the assert time never touch power-good. Instead they are tallied in a saturating event counter that a separate policy block can read and clear.

Top module: `rail_window_supervisor`

## Requirements
- R1: After reset, `pgood` is 0 and `evt_count` is 0. While `en` is low, `pgood` is 0 from the cycle after `en` falls, and the grace interval restarts on the next enable.
- R2: After `en` rises, both flags are ignored for `grace_ticks` ticks: they neither change `pgood` nor add events, and an overvoltage during this interval can cause no trip. A `grace_ticks` of 0 ends grace one cycle after enable.
- R3: After grace ends, `pgood` becomes 1 only once undervoltage has been clear for `uv_release_ticks` consecutive ticks and overvoltage has been clear for `ov_release_ticks` consecutive ticks.
- R4: An undervoltage flag held through `uv_assert_ticks` ticks drops `pgood` in the cycle after the last of those ticks. A shorter hold leaves `pgood` at 1.
- R5: An overvoltage flag held through `ov_assert_ticks` ticks drops `pgood` in the same way. A shorter hold leaves `pgood` at 1.
- R6: Any clock cycle in which a qualifier's input condition breaks restarts that qualifier's count from zero. This applies to both assert and release counts.
- R7: While a direction is qualified good, a flag that goes high and then low before its assert time is reached adds 1 to `evt_count`. Excursions ending in the same cycle in both directions add 2.
- R8: `evt_count` saturates at 2^EVT_W−1. `evt_clr` sets it to 0 on the next cycle and takes priority over any increment in that cycle.
- R9: Counts advance only in cycles where `tick` is 1, so a flag held without ticks never trips. Both flags active at once is a fault, and an assert limit of 0 trips on the first tick.
- R10: `pgood` rises only in the cycle after a tick. It falls only in the cycle after a tick or after `en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle time base enable |
| en | input | 1 | Supervisor enable; rising starts the grace interval |
| uv_flag | input | 1 | Synchronized undervoltage comparator flag |
| ov_flag | input | 1 | Synchronized overvoltage comparator flag |
| grace_ticks | input | TIMER_W | Grace interval length in ticks |
| uv_assert_ticks | input | TIMER_W | Undervoltage assert time in ticks |
| uv_release_ticks | input | TIMER_W | Undervoltage release time in ticks |
| ov_assert_ticks | input | TIMER_W | Overvoltage assert time in ticks |
| ov_release_ticks | input | TIMER_W | Overvoltage release time in ticks |
| evt_clr | input | 1 | Clears the excursion counter |
| pgood | output | 1 | Power-good: rail qualified inside the window |
| evt_count | output | EVT_W | Saturating count of short excursions |

## Verification
The bound checker watches, on every cycle, the properties that need no notion of configured times. These are: power-good dropping while disabled, staying low right after enable, and changing only after a tick or a disable. They also cover the counter clearing, holding at saturation, and never stepping by more than two. Exact tick counts for assert and release in each direction need the bench's directed scenarios. So do restarts caused by a one-cycle break, masking of both flags during grace, the simultaneous-flag fault and the zero-limit corner.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic {
        Q_FAULT = 1'b0,
        Q_OK    = 1'b1
    } qual_state_e;

    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_UV  = 0;
    localparam int unsigned DIR_OV  = 1;

    function automatic int unsigned sat_add(input int unsigned base,
                                            input int unsigned inc,
                                            input int unsigned ceiling);
        int unsigned sum;
        sum = base + inc;
        return (sum > ceiling) ? ceiling : sum;
    endfunction

endpackage

// File: rtl/supv_grace_timer.sv
module supv_grace_timer #(
    parameter int unsigned TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               tick,
    input  logic [TIMER_W-1:0] grace_len,
    output logic               grace_done
);
    logic [TIMER_W-1:0] cnt;
    logic [TIMER_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt        <= '0;
            grace_done <= 1'b0;
        end else if (!grace_done) begin
            if (grace_len == '0) begin
                grace_done <= 1'b1;
            end else if (tick) begin
                if (cnt_nxt >= {1'b0, grace_len}) begin
                    grace_done <= 1'b1;
                    cnt        <= '0;
                end else begin
                    cnt <= cnt_nxt[TIMER_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/supv_fault_qualifier.sv
module supv_fault_qualifier
    import supv_pkg::*;
#(
    parameter int unsigned TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tick,
    input  logic               cond,
    input  logic [TIMER_W-1:0] assert_lim,
    input  logic [TIMER_W-1:0] release_lim,
    output logic               ok,
    output logic               excursion
);
    qual_state_e        state;
    logic [TIMER_W-1:0] cnt;
    logic [TIMER_W:0]   cnt_nxt;
    logic               pending;

    assign cnt_nxt   = {1'b0, cnt} + 1'b1;
    assign ok        = (state == Q_OK);
    assign excursion = run && (state == Q_OK) && pending && !cond;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state   <= Q_FAULT;
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            unique case (state)
                Q_OK: begin
                    if (!cond) begin
                        cnt     <= '0;
                        pending <= 1'b0;
                    end else begin
                        pending <= 1'b1;
                        if (tick) begin
                            if (cnt_nxt >= {1'b0, assert_lim}) begin
                                state   <= Q_FAULT;
                                cnt     <= '0;
                                pending <= 1'b0;
                            end else begin
                                cnt <= cnt_nxt[TIMER_W-1:0];
                            end
                        end
                    end
                end
                Q_FAULT: begin
                    pending <= 1'b0;
                    if (cond) begin
                        cnt <= '0;
                    end else if (tick) begin
                        if (cnt_nxt >= {1'b0, release_lim}) begin
                            state <= Q_OK;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt_nxt[TIMER_W-1:0];
                        end
                    end
                end
                default: state <= Q_FAULT;
            endcase
        end
    end
endmodule

// File: rtl/supv_event_tally.sv
module supv_event_tally
    import supv_pkg::*;
#(
    parameter int unsigned EVT_W   = 8,
    parameter int unsigned NUM_SRC = NUM_DIR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [NUM_SRC-1:0] hit,
    output logic [EVT_W-1:0]   count
);
    localparam int unsigned CEIL = (1 << EVT_W) - 1;

    int unsigned inc;

    always_comb begin
        inc = 0;
        for (int i = 0; i < NUM_SRC; i++) begin
            inc = inc + int'(hit[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else begin
            count <= EVT_W'(sat_add(int'(count), inc, CEIL));
        end
    end
endmodule

// File: rtl/rail_window_supervisor.sv
module rail_window_supervisor
    import supv_pkg::*;
#(
    parameter int unsigned TIMER_W = 16,
    parameter int unsigned EVT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               en,
    input  logic               uv_flag,
    input  logic               ov_flag,
    input  logic [TIMER_W-1:0] grace_ticks,
    input  logic [TIMER_W-1:0] uv_assert_ticks,
    input  logic [TIMER_W-1:0] uv_release_ticks,
    input  logic [TIMER_W-1:0] ov_assert_ticks,
    input  logic [TIMER_W-1:0] ov_release_ticks,
    input  logic               evt_clr,
    output logic               pgood,
    output logic [EVT_W-1:0]   evt_count
);
    logic                     grace_done;
    logic [NUM_DIR-1:0]       dir_flag;
    logic [NUM_DIR-1:0]       dir_ok;
    logic [NUM_DIR-1:0]       dir_exc;
    logic [TIMER_W-1:0]       lim_assert  [NUM_DIR];
    logic [TIMER_W-1:0]       lim_release [NUM_DIR];

    assign dir_flag[DIR_UV]    = uv_flag;
    assign dir_flag[DIR_OV]    = ov_flag;
    assign lim_assert[DIR_UV]  = uv_assert_ticks;
    assign lim_assert[DIR_OV]  = ov_assert_ticks;
    assign lim_release[DIR_UV] = uv_release_ticks;
    assign lim_release[DIR_OV] = ov_release_ticks;

    supv_grace_timer #(.TIMER_W(TIMER_W)) u_grace (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (tick),
        .grace_len  (grace_ticks),
        .grace_done (grace_done)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        supv_fault_qualifier #(.TIMER_W(TIMER_W)) u_qual (
            .clk         (clk),
            .rst         (rst),
            .run         (grace_done),
            .tick        (tick),
            .cond        (dir_flag[d]),
            .assert_lim  (lim_assert[d]),
            .release_lim (lim_release[d]),
            .ok          (dir_ok[d]),
            .excursion   (dir_exc[d])
        );
    end

    supv_event_tally #(.EVT_W(EVT_W), .NUM_SRC(NUM_DIR)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clr   (evt_clr),
        .hit   (dir_exc),
        .count (evt_count)
    );

    assign pgood = grace_done && (&dir_ok);
endmodule

module supv_checker #(
    parameter int unsigned EVT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             en,
    input logic             evt_clr,
    input logic             pgood,
    input logic [EVT_W-1:0] evt_count
);
    localparam logic [EVT_W-1:0] CEIL = '1;

    // R1
    disabled_pg_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pgood);

    // R2
    enable_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> !pgood);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        evt_clr |=> (evt_count == '0));

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_count == CEIL && !evt_clr) |=> (evt_count == CEIL));

    // R7
    no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_clr |=> (evt_count >= $past(evt_count)));

    // R7
    step_limit_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_clr |=> ((evt_count - $past(evt_count)) <= EVT_W'(2)));

    // R10
    pg_rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pgood) |-> ($past(tick) && $past(en)));

    // R10
    pg_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pgood) |-> ($past(tick) || !$past(en)));
endmodule

bind rail_window_supervisor supv_checker #(.EVT_W(EVT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .en        (en),
    .evt_clr   (evt_clr),
    .pgood     (pgood),
    .evt_count (evt_count)
);

// File: tb/rail_window_supervisor_tb.sv
module rail_window_supervisor_tb;
    localparam int unsigned TW = 8;
    localparam int unsigned EW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          en = 1'b0;
    logic          uv = 1'b0;
    logic          ov = 1'b0;
    logic [TW-1:0] grace = TW'(5);
    logic [TW-1:0] uv_a = TW'(2);
    logic [TW-1:0] uv_r = TW'(4);
    logic [TW-1:0] ov_a = TW'(3);
    logic [TW-1:0] ov_r = TW'(6);
    logic          clr = 1'b0;
    logic          pgood;
    logic [EW-1:0] evt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rail_window_supervisor #(.TIMER_W(TW), .EVT_W(EW)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .en(en),
        .uv_flag(uv), .ov_flag(ov),
        .grace_ticks(grace), .uv_assert_ticks(uv_a), .uv_release_ticks(uv_r),
        .ov_assert_ticks(ov_a), .ov_release_ticks(ov_r),
        .evt_clr(clr), .pgood(pgood), .evt_count(evt)
    );

    task automatic chk_pg(input logic exp, input string req);
        checks++;
        if (pgood !== exp) begin
            errors++;
            $display("FAIL %s pgood actual %0b expected %0b", req, pgood, exp);
        end
    endtask

    task automatic chk_evt(input int exp, input string req);
        checks++;
        if (int'(evt) != exp) begin
            errors++;
            $display("FAIL %s evt_count actual %0d expected %0d", req, evt, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk_pg(1'b0, "R1");
        chk_evt(0, "R1");
    endtask

    task automatic t_grace_startup;
        en = 1'b1; uv = 1'b1; ov = 1'b1;
        idle(1);
        chk_pg(1'b0, "R2");
        ticks(4);
        chk_pg(1'b0, "R2");
        chk_evt(0, "R2");
        uv = 1'b0; ov = 1'b0;
        ticks(1);
        ticks(5);
        chk_pg(1'b0, "R3");
        ticks(1);
        chk_pg(1'b1, "R3");
        chk_evt(0, "R2");
    endtask

    task automatic t_uv_short;
        uv = 1'b1;
        ticks(1);
        chk_pg(1'b1, "R4");
        uv = 1'b0;
        idle(1);
        chk_evt(1, "R7");
        uv = 1'b1;
        idle(1);
        uv = 1'b0;
        idle(1);
        chk_evt(2, "R7");
        chk_pg(1'b1, "R7");
    endtask

    task automatic t_uv_fault_release;
        uv = 1'b1;
        ticks(1);
        chk_pg(1'b1, "R4");
        ticks(1);
        chk_pg(1'b0, "R4");
        uv = 1'b0;
        ticks(3);
        uv = 1'b1;
        idle(1);
        uv = 1'b0;
        ticks(3);
        chk_pg(1'b0, "R6");
        ticks(1);
        chk_pg(1'b1, "R6");
        chk_evt(2, "R4");
    endtask

    task automatic t_ov_fault_release;
        ov = 1'b1;
        ticks(2);
        chk_pg(1'b1, "R5");
        ticks(1);
        chk_pg(1'b0, "R5");
        ov = 1'b0;
        ticks(5);
        chk_pg(1'b0, "R3");
        ticks(1);
        chk_pg(1'b1, "R3");
        chk_evt(2, "R5");
    endtask

    task automatic t_both_and_notick;
        uv = 1'b1; ov = 1'b1;
        ticks(2);
        chk_pg(1'b0, "R9");
        uv = 1'b0; ov = 1'b0;
        idle(1);
        chk_evt(3, "R7");
        ticks(3);
        chk_pg(1'b0, "R3");
        ticks(1);
        chk_pg(1'b1, "R3");
        uv = 1'b1;
        idle(10);
        chk_pg(1'b1, "R9");
        uv = 1'b0;
        idle(1);
        chk_evt(4, "R9");
        uv_a = '0;
        uv = 1'b1;
        ticks(1);
        chk_pg(1'b0, "R9");
        uv = 1'b0;
        uv_a = TW'(2);
        ticks(4);
        chk_pg(1'b1, "R9");
    endtask

    task automatic t_saturate_clear;
        clr = 1'b1;
        idle(1);
        clr = 1'b0;
        chk_evt(0, "R8");
        uv = 1'b1; ov = 1'b1;
        idle(1);
        uv = 1'b0; ov = 1'b0;
        idle(1);
        chk_evt(2, "R7");
        for (int i = 0; i < 7; i++) begin
            uv = 1'b1;
            idle(1);
            uv = 1'b0;
            idle(1);
        end
        chk_evt(7, "R8");
        uv = 1'b1;
        idle(1);
        uv = 1'b0; clr = 1'b1;
        idle(1);
        clr = 1'b0;
        chk_evt(0, "R8");
        chk_pg(1'b1, "R8");
    endtask

    task automatic t_disable_reenable;
        en = 1'b0;
        idle(1);
        chk_pg(1'b0, "R1");
        grace = '0;
        ov = 1'b1;
        en = 1'b1;
        idle(1);
        ov = 1'b0;
        idle(1);
        chk_evt(0, "R2");
        ticks(5);
        chk_pg(1'b0, "R2");
        ticks(1);
        chk_pg(1'b1, "R2");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_grace_startup();
        t_uv_short();
        t_uv_fault_release();
        t_ov_fault_release();
        t_both_and_notick();
        t_saturate_clear();
        t_disable_reenable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule